// File: doc/BRIEF.md
# Rotating General Register File

This block is an integer register file of 128 physical entries. Names in the lower part of the name space point directly at the physical register of the same number. Names in the upper part go through a rename offset first, and that offset can be loaded or stepped. Software-pipelined loops use this so that one loop body can reuse the same register names on every iteration. Each time the offset is stepped, a value produced under name r is found under name r+1.

There are two combinational read ports and one write port. All three take 7-bit names and translate them with the same rule. The offset is held in a small register and is the only state that reset touches. Physical register 0 always reads as zero.

Top module: `rot_regfile`

## Requirements
- R1: After reset the offset is 0, so every name n reads and writes physical register n.
- R2: Names 0 to 31 always select physical registers 0 to 31, whatever the offset.
- R3: A name n of 32 or more selects physical register 32 + ((n - 32 + offset) mod 96). It never reaches a physical register below 32.
- R4: Reading physical register 0 returns zero on both read ports. A write to it is discarded.
- R5: A pulse on `rot_step` decrements the offset modulo 96, so 0 becomes 95. After the step, the value written under name r (32 ≤ r ≤ 126) reads under name r+1, and the value under name 127 reads under name 32.
- R6: A pulse on `ofs_load` with `ofs_value` below 96 sets the offset to `ofs_value`. If `ofs_value` is 96 or more, the offset keeps its value. When `ofs_load` and `rot_step` are both high in a cycle, the load is applied and the step has no effect.
- R7: A write in the same cycle as a step or a load is placed using the offset that held before that edge.
- R8: Reads are combinational and use the current offset. Reading the register that is being written returns the old contents until the clock edge. The two read ports work independently.
- R9: In a cycle where neither `ofs_load` nor `rot_step` is high, the offset does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (clears the offset only) |
| rd_a_name | input | 7 | Read port A register name |
| rd_a_data | output | 64 | Read port A data |
| rd_b_name | input | 7 | Read port B register name |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_name | input | 7 | Write register name |
| wr_data | input | 64 | Write data |
| ofs_load | input | 1 | Load the offset from ofs_value |
| ofs_value | input | 7 | New offset value (values of 96 and above are ignored) |
| rot_step | input | 1 | Decrement the offset modulo 96 |

## Verification
The bench fills every name and then checks all 128 names on both ports after each offset change. This covers the wrap from name 127 to name 32, the step from offset 0 to 95, and a sweep of loaded offsets. A design that added the offset to static names, or wrapped modulo 128, would let upper names land on physical registers 0 to 31 and would return the wrong static values. The bench also drives a write together with a step, a read of the register under write before its edge, a load of an out-of-range value, a load and a step in the same cycle, and a write to name 0. These cases expose the wrong offset being used for the write, a read that bypasses the new data, a clamped or truncated offset, the wrong priority between load and step, and a physical register 0 that holds data.

// File: rtl/rot_regfile.sv
module rot_regfile #(
  parameter int DATA_W     = 64,
  parameter int NUM_REGS   = 128,
  parameter int NUM_STATIC = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(NUM_REGS)-1:0] rd_a_name,
  output logic [DATA_W-1:0]           rd_a_data,
  input  logic [$clog2(NUM_REGS)-1:0] rd_b_name,
  output logic [DATA_W-1:0]           rd_b_data,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_REGS)-1:0] wr_name,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        ofs_load,
  input  logic [$clog2(NUM_REGS)-1:0] ofs_value,
  input  logic                        rot_step
);
  localparam int NAME_W = $clog2(NUM_REGS);
  localparam int ROT_N  = NUM_REGS - NUM_STATIC;

  logic [NAME_W-1:0] ofs_q;
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [NAME_W-1:0] rd_a_phys, rd_b_phys, wr_phys;

  function automatic logic [NAME_W-1:0] map_name(input logic [NAME_W-1:0] n,
                                                 input logic [NAME_W-1:0] o);
    int s;
    if (int'(n) < NUM_STATIC) return n;
    s = int'(n) - NUM_STATIC + int'(o);
    if (s >= ROT_N) s = s - ROT_N;
    return NAME_W'(NUM_STATIC + s);
  endfunction

  assign rd_a_phys = map_name(rd_a_name, ofs_q);
  assign rd_b_phys = map_name(rd_b_name, ofs_q);
  assign wr_phys   = map_name(wr_name, ofs_q);

  assign rd_a_data = (rd_a_phys == '0) ? '0 : regs_q[rd_a_phys];
  assign rd_b_data = (rd_b_phys == '0) ? '0 : regs_q[rd_b_phys];

  always_ff @(posedge clk) begin
    if (wr_en && wr_phys != '0) regs_q[wr_phys] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q <= '0;
    end else if (ofs_load) begin
      if (int'(ofs_value) < ROT_N) ofs_q <= ofs_value;
    end else if (rot_step) begin
      ofs_q <= (ofs_q == '0) ? NAME_W'(ROT_N - 1) : ofs_q - 1'b1;
    end
  end

  // R3
  ofs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ofs_q) < ROT_N);

  // R4
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_name == '0) |-> (rd_a_data == '0));

  // R5
  rot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_step && !ofs_load && ofs_q == '0) |=> (int'(ofs_q) == ROT_N - 1));

  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_load && int'(ofs_value) < ROT_N) |=> (ofs_q == $past(ofs_value)));

  // R9
  ofs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ofs_load && !rot_step) |=> $stable(ofs_q));
endmodule

// File: tb/rot_regfile_tb_top.sv
`timescale 1ns/1ps
module rot_regfile_tb_top;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [6:0]    rd_a_name = '0, rd_b_name = '0, wr_name = '0, ofs_value = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic          wr_en = 1'b0, ofs_load = 1'b0, rot_step = 1'b0;

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [DW-1:0] mem_m [128];
  int ofs_m = 0;

  always #2.5 clk = ~clk;

  rot_regfile dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_a_name(rd_a_name), .rd_a_data(rd_a_data),
    .rd_b_name(rd_b_name), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_name(wr_name), .wr_data(wr_data),
    .ofs_load(ofs_load), .ofs_value(ofs_value), .rot_step(rot_step)
  );

  function automatic int phys(int n, int o);
    if (n < 32) return n;
    return 32 + ((n - 32 + o) % 96);
  endfunction

  function automatic logic [DW-1:0] pat(int n, int tag);
    return {32'(n) * 32'h9E37_79B1, 32'(tag) ^ 32'h5A00_0000 ^ 32'(n)};
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(bit we, int name, logic [DW-1:0] d, bit ld, int lv, bit rot);
    @(negedge clk);
    wr_en = we; wr_name = 7'(name); wr_data = d;
    ofs_load = ld; ofs_value = 7'(lv); rot_step = rot;
    @(posedge clk);
    #1;
    wr_en = 0; ofs_load = 0; rot_step = 0;
    if (we && phys(name, ofs_m) != 0) mem_m[phys(name, ofs_m)] = d;
    if (ld) begin
      if (lv < 96) ofs_m = lv;
    end else if (rot) ofs_m = (ofs_m == 0) ? 95 : ofs_m - 1;
  endtask

  task automatic sweep(string req);
    for (int n = 0; n < 128; n++) begin
      rd_a_name = 7'(n);
      rd_b_name = 7'((n + 37) % 128);
      #0.01;
      chk(req, rd_a_data, mem_m[phys(n, ofs_m)]);
      chk(req, rd_b_data, mem_m[phys((n + 37) % 128, ofs_m)]);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] s127;
    for (int i = 0; i < 128; i++) mem_m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 R4: fill all names at offset 0, name 0 discarded
    for (int n = 0; n < 128; n++) cycle(1, n, pat(n, 1), 0, 0, 0);
    sweep("R1");
    rd_a_name = 0; #0.01; chk("R4", rd_a_data, '0);

    // R5: single step, r -> r+1, 127 -> 32, static fixed
    rd_a_name = 127; #0.01; s127 = rd_a_data;
    cycle(0, 0, '0, 0, 0, 1);
    rd_a_name = 32; #0.01; chk("R5", rd_a_data, s127);
    for (int r = 32; r < 127; r++) begin
      rd_b_name = 7'(r + 1); #0.01; chk("R5", rd_b_data, pat(r, 1));
    end
    for (int r = 1; r < 32; r++) begin
      rd_b_name = 7'(r); #0.01; chk("R2", rd_b_data, pat(r, 1));
    end
    sweep("R3");

    // R9: idle cycles keep mapping
    repeat (4) cycle(0, 0, '0, 0, 0, 0);
    sweep("R9");

    // R6: load sweep
    for (int o = 0; o < 96; o += 19) begin
      cycle(0, 0, '0, 1, o, 0);
      sweep("R6");
    end
    cycle(0, 0, '0, 1, 95, 0);
    sweep("R3");
    // R6: out of range ignored
    cycle(0, 0, '0, 1, 96, 0);
    sweep("R6");
    cycle(0, 0, '0, 1, 127, 0);
    sweep("R6");
    // R6: load beats step
    cycle(0, 0, '0, 1, 10, 1);
    sweep("R6");

    // R5: step from 0 wraps to 95
    cycle(0, 0, '0, 1, 0, 0);
    cycle(0, 0, '0, 0, 0, 1);
    sweep("R5");

    // R7: write alongside step and load uses old offset
    cycle(1, 50, pat(50, 7), 0, 0, 1);
    sweep("R7");
    cycle(1, 127, pat(127, 8), 1, 40, 0);
    sweep("R7");
    cycle(1, 5, pat(5, 9), 0, 0, 1);
    sweep("R7");

    // R8: read of register under write returns old until edge
    @(negedge clk);
    wr_en = 1; wr_name = 7'd60; wr_data = pat(60, 11);
    rd_a_name = 7'd60; rd_b_name = 7'd61; #0.5;
    chk("R8", rd_a_data, mem_m[phys(60, ofs_m)]);
    chk("R8", rd_b_data, mem_m[phys(61, ofs_m)]);
    @(posedge clk); #1;
    wr_en = 0;
    mem_m[phys(60, ofs_m)] = pat(60, 11);
    #0.01; chk("R8", rd_a_data, pat(60, 11));

    // R4: write to name 0 discarded
    cycle(1, 0, pat(0, 12), 0, 0, 0);
    rd_a_name = 0; rd_b_name = 0; #0.01;
    chk("R4", rd_a_data, '0);
    chk("R4", rd_b_data, '0);

    // R2: refill under nonzero offset, check static unchanged by further steps
    for (int n = 0; n < 128; n++) cycle(1, n, pat(n, 13), 0, 0, 0);
    repeat (3) cycle(0, 0, '0, 0, 0, 1);
    sweep("R2");

    finished = 1;
    finish_run();
  end
endmodule